// File: doc/BRIEF.md
# Tagged Token Matching Unit

This block sits at the input of a dataflow processing element. Each arriving token carries a tag and one data word. The tag names one execution of an instruction, and that name includes the destination instruction address. An instruction with two operands can only run once both of its tokens are present. The block keeps the tokens that are still missing a partner in a small, fully associative waiting store. Each new token is compared against every waiting entry at once.

When the partner of a new token is already waiting, the block frees that entry. It then presents the tag and both data words as one packet to the fetch stage that follows. When no partner is waiting, the new token is written into a free entry and nothing is sent out. The instruction address is used only after both operands are present. The fetch stage reads it from the tag of the packet.

Tag bit 0 is the operand port: 0 marks the left operand and 1 marks the right operand. Bits `TAG_W-1:1` form the match key. On the output, the left operand always goes in `out_left`, whatever the arrival order. The input and the output are both valid/ready channels.

Top module: `token_match`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and the waiting store is empty. An empty store means the first token of any key produces no output.
- R2: If no waiting entry has the same key (tag bits `TAG_W-1:1`) as an accepted token, the token is stored and `out_valid` stays 0 in the following cycle.
- R3: If a waiting entry has the same key as an accepted token, `out_valid` is 1 in the following cycle. `out_tag` then holds the key in bits `TAG_W-1:1` and a 0 in bit 0.
- R4: In a matched packet, `out_left` carries the data of the token whose tag bit 0 was 0, and `out_right` carries the data of the token whose tag bit 0 was 1. This holds for either arrival order.
- R5: A matched entry is freed in the same cycle that its packet is produced. A later token with the same key is therefore stored again and does not match.
- R6: With all `DEPTH` entries occupied (default 16), `in_ready` is 0 for a token whose key matches no entry, and 1 for a token whose key matches an entry.
- R7: While `out_valid` is 1 and `out_ready` is 0, the output fields hold steady and `in_ready` is 0.
- R8: In a cycle where the pending packet is taken and a new matching token is accepted, `out_valid` stays 1. The new packet replaces the old one with no empty cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming token is present |
| in_ready | output | 1 | Block accepts the token in this cycle |
| in_tag | input | TAG_W | Key in bits TAG_W-1:1, operand port in bit 0 |
| in_data | input | DATA_W | Operand value |
| out_valid | output | 1 | Matched packet is present |
| out_ready | input | 1 | Fetch stage takes the packet |
| out_tag | output | TAG_W | Key of the pair, bit 0 cleared |
| out_left | output | DATA_W | Left operand |
| out_right | output | DATA_W | Right operand |

## Verification
Two functions can fall in the same cycle: the fetch stage draining the pending packet, and a new matching token freeing its entry and loading the output register. The bench provokes this by holding `out_ready` high and delivering the second half of one pair in the cycle right after another pair was produced. It expects `out_valid` to stay high across that edge while the tag and operands change to the new pair. A second overlap comes with a full store: a matching token must still be admitted, while a non-matching token is refused. The bench checks this by looking at `in_ready` for both kinds of token before the edge.

// File: rtl/token_match.sv
module token_match #(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [TAG_W-1:0]  out_tag,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right
);
  localparam int KEY_W = TAG_W - 1;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  vld;
  logic [KEY_W-1:0]  key_q [DEPTH];
  logic [DATA_W-1:0] dat_q [DEPTH];
  logic [DEPTH-1:0]  hit_vec;
  logic [IDX_W-1:0]  hit_idx, free_idx;
  logic              hit, full, stall, take;
  logic [KEY_W-1:0]  in_key;

  assign in_key = in_tag[TAG_W-1:1];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_vec[i] = vld[i] && (key_q[i] == in_key);
  end

  assign hit      = |hit_vec;
  assign full     = &vld;
  assign stall    = out_valid && !out_ready;
  assign in_ready = !stall && (hit || !full);
  assign take     = in_valid && in_ready;

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
      if (!vld[i])    free_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld       <= '0;
      out_valid <= 1'b0;
      out_tag   <= '0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (take && hit) begin
        vld[hit_idx] <= 1'b0;
        out_valid    <= 1'b1;
        out_tag      <= {in_key, 1'b0};
        if (in_tag[0]) begin
          out_left  <= dat_q[hit_idx];
          out_right <= in_data;
        end else begin
          out_left  <= in_data;
          out_right <= dat_q[hit_idx];
        end
      end else if (take) begin
        vld[free_idx]   <= 1'b1;
        key_q[free_idx] <= in_key;
        dat_q[free_idx] <= in_data;
      end
    end
  end
endmodule

// File: rtl/token_match_chk.sv
module token_match_chk #(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [TAG_W-1:0]  out_tag,
  input logic [DATA_W-1:0] out_left,
  input logic [DATA_W-1:0] out_right,
  input logic              hit,
  input logic              full
);
  // R2
  store_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !hit) |=> !out_valid);

  // R3
  match_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && hit) |=> (out_valid && !out_tag[0]));

  // R6
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !hit) |-> !in_ready);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_tag) && $stable(out_left) && $stable(out_right)));

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8
  no_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && in_valid && in_ready && hit) |=> out_valid);
endmodule

bind token_match token_match_chk #(.TAG_W(TAG_W), .DATA_W(DATA_W)) chk (.*);

// File: tb/token_match_test.sv
module token_match_test;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 8;
  localparam int DATA_W = 16;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [TAG_W-1:0] in_tag = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [TAG_W-1:0] out_tag;
  logic [DATA_W-1:0] out_left, out_right;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  token_match #(.TAG_W(TAG_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) uut (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic logic [TAG_W-1:0] mk(int key, bit port);
    return {7'(key), port};
  endfunction

  function automatic logic [DATA_W-1:0] val(int key, bit port);
    return {8'(key), 8'(port ? 8'hB2 : 8'hA1)};
  endfunction

  task automatic put(int key, bit port);
    @(negedge clk);
    in_valid = 1'b1;
    in_tag = mk(key, port);
    in_data = val(key, port);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic expect_pair(string req, int key);
    check({req, " valid"}, 32'(out_valid), 1);
    check({req, " tag"}, 32'(out_tag), 32'(mk(key, 1'b0)));
    check({req, " left"}, 32'(out_left), 32'(val(key, 1'b0)));
    check({req, " right"}, 32'(out_right), 32'(val(key, 1'b1)));
  endtask

  task automatic t_reset;
    check("R1 out_valid", 32'(out_valid), 0);
    check("R1 in_ready", 32'(in_ready), 1);
    put(3, 1'b1);
    check("R1 empty store", 32'(out_valid), 0);
    put(3, 1'b0);
    expect_pair("R1 drain", 3);
  endtask

  task automatic t_basic;
    put(5, 1'b0);
    check("R2 no output", 32'(out_valid), 0);
    put(5, 1'b1);
    expect_pair("R3 pair", 5);
  endtask

  task automatic t_reverse;
    put(6, 1'b1);
    check("R4 stored", 32'(out_valid), 0);
    put(6, 1'b0);
    expect_pair("R4 order", 6);
  endtask

  task automatic t_reuse;
    put(5, 1'b1);
    check("R5 freed", 32'(out_valid), 0);
    put(5, 1'b0);
    expect_pair("R5 rematch", 5);
  endtask

  task automatic t_scramble;
    for (int k = 10; k < 16; k++) put(k, 1'b1);
    for (int k = 15; k >= 10; k--) begin
      put(k, 1'b0);
      expect_pair("R3 scrambled", k);
    end
  endtask

  task automatic t_full;
    for (int k = 20; k < 20 + DEPTH; k++) begin
      put(k, 1'b0);
      check("R2 fill", 32'(out_valid), 0);
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_tag = mk(60, 1'b0);
    in_data = val(60, 1'b0);
    #1;
    check("R6 full nonmatch", 32'(in_ready), 0);
    in_tag = mk(20, 1'b1);
    in_data = val(20, 1'b1);
    #1;
    check("R6 full match", 32'(in_ready), 1);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    expect_pair("R6 pair", 20);
    for (int k = 21; k < 20 + DEPTH; k++) begin
      put(k, 1'b1);
      expect_pair("R6 drain", k);
    end
  endtask

  task automatic t_stall;
    put(50, 1'b1);
    out_ready = 1'b0;
    put(50, 1'b0);
    in_valid = 1'b1;
    in_tag = mk(51, 1'b0);
    in_data = val(51, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    expect_pair("R7 hold", 50);
    check("R7 in_ready", 32'(in_ready), 0);
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    check("R7 released", 32'(out_valid), 0);
  endtask

  task automatic t_overlap;
    put(40, 1'b0);
    put(41, 1'b0);
    put(40, 1'b1);
    expect_pair("R8 first", 40);
    put(41, 1'b1);
    expect_pair("R8 back-to-back", 41);
    @(posedge clk);
    #1;
    check("R8 empty after", 32'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset;
    t_basic;
    t_reverse;
    t_reuse;
    t_scramble;
    t_full;
    t_stall;
    t_overlap;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog got=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule